// File: doc/BRIEF.md
# Processor System Bus Ownership Controller

This block is the processor-side controller for a shared, multiplexed address/data bus and its companion command bus. The processor and an external agent can both drive these buses, and ownership passes between them through a request/release handshake. While the processor owns the buses, it can issue a read. It drives the address and a read command with an active-low valid strobe, and holds them until the agent signals read-ready. It then stops driving, pulses an active-low release strobe for one cycle, and collects the response words the agent returns.

The agent can also take the buses on its own by pulling an active-low external-request line. While it owns the buses, it can send two kinds of command, each marked by an active-low valid-in strobe. A null command returns ownership to the processor. A write command, followed by one data word, updates an internal register that the rest of the chip sees as `wr_reg_o`. A read ends, and ownership returns, when a data word carrying the end-of-data flag arrives.

The block sits between the processor's load/store logic and the pad ring. The separate output-enable drives the bidirectional pad cells.

Top module: `bus_own_ctrl`

## Requirements
- R1: After reset the release strobe and the valid-out strobe are high, the output-enable is high, and `wr_reg_o`, `rd_data_valid_o` and `rd_done_o` are 0.
- R2: A read request accepted while the processor owns the idle bus (`rd_ack_o`=1) has an effect in the next cycle. In that cycle `valid_out_no` is low, `bus_data_o` carries the latched address, `cmd_o` is the read command 4'b0100, and `bus_oe_o` is high.
- R3: When read-ready is low at a clock edge while a read is being driven, the next cycle has `release_no` low, `valid_out_no` high and `bus_oe_o` low. The release pulse lasts exactly one cycle.
- R4: While a read is driven and read-ready stays high, the valid-out strobe, the address and the command stay unchanged and no release occurs.
- R5: External-request low while the processor owns the idle bus gives a one-cycle release in the next cycle. It wins over a read request in the same cycle, which is then not accepted (`rd_ack_o`=0).
- R6: After a read release, each word sampled with `valid_in_ni` low and `cmd_i[3]`=1 appears on `rd_data_o` with `rd_data_valid_o` high in the following cycle. This holds in order and across idle gaps, for a four-word block.
- R7: A read-response data word with `cmd_i[0]`=1 (end of data) ends the read. In the following cycle `rd_done_o` pulses and `bus_oe_o` is high again.
- R8: A null command (`cmd_i`=4'b0000, valid-in low) while the agent owns the buses makes `bus_oe_o` high in the following cycle.
- R9: A write command (`cmd_i`=4'b0010) followed by a data word loads that word into `wr_reg_o`. The word is not reported as read data, and it does not end a read even if it carries the end-of-data flag.
- R10: `valid_in_ni` is ignored while the processor owns the buses. Commands and data sent then change neither `wr_reg_o` nor the read outputs.
- R11: `bus_oe_o` is never high while `release_no` is low. It is always high while `valid_out_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Request to issue a block read |
| rd_addr_i | input | DW | Read address |
| rd_ack_o | output | 1 | Read request accepted this cycle |
| rd_data_o | output | DW | Last read-response word |
| rd_data_valid_o | output | 1 | `rd_data_o` holds a new word |
| rd_done_o | output | 1 | Read finished (end-of-data seen) |
| wr_reg_o | output | DW | Register written by external write requests |
| bus_data_o | output | DW | Address/data bus, outgoing value |
| bus_data_i | input | DW | Address/data bus, incoming value |
| cmd_o | output | 4 | Command bus, outgoing value |
| cmd_i | input | 4 | Command bus, incoming value |
| bus_oe_o | output | 1 | Output-enable for both bus pad groups |
| valid_out_no | output | 1 | Processor drives a valid command, active low |
| valid_in_ni | input | 1 | Agent drives a valid command or word, active low |
| rd_rdy_ni | input | 1 | Agent can accept a read, active low |
| ext_req_ni | input | 1 | Agent requests the buses, active low |
| release_no | output | 1 | Processor releases the buses, active low |

## Verification
A wrong ownership state shows up within one cycle. It appears as an output-enable that is high during a release or while the agent could be sending, or as a missing or doubled release pulse. A wrong read or write decode also shows up at the ports. The `rd_data_valid_o` stream then has an extra, missing or misordered word in the cycle after the offending `valid_in_ni` strobe. Otherwise `wr_reg_o` changes when it should hold. A lost end-of-data or null decode leaves `bus_oe_o` low in the cycle where it should have returned.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;
  localparam int unsigned CMD_W = 4;
  // cmd[3]=1: data word, cmd[0]=end of data; cmd[3]=0: command, opcode in cmd[2:1]
  localparam int unsigned CMD_DATA_BIT = 3;
  localparam int unsigned CMD_EOD_BIT  = 0;
  localparam logic [1:0]  OP_NULL  = 2'b00;
  localparam logic [1:0]  OP_WRITE = 2'b01;
  localparam logic [1:0]  OP_READ  = 2'b10;
  localparam logic [CMD_W-1:0] CMD_READ = {1'b0, OP_READ, 1'b0};
  localparam logic [CMD_W-1:0] CMD_IDLE = {1'b0, OP_NULL, 1'b0};

  typedef enum logic [2:0] {
    ST_OWN,
    ST_REQ,
    ST_REL_RD,
    ST_REL_EXT,
    ST_SLV_RD,
    ST_SLV_EXT
  } own_state_e;
endpackage

// File: rtl/bus_own_fsm.sv
module bus_own_fsm
  import bus_own_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_req_i,
  input  logic [DW-1:0] rd_addr_i,
  input  logic          rd_rdy_ni,
  input  logic          ext_req_ni,
  input  logic          null_i,
  input  logic          rd_end_i,
  output logic          rd_ack_o,
  output logic          drive_o,
  output logic          req_o,
  output logic          rel_o,
  output logic          slave_o,
  output logic          slave_rd_o,
  output logic [DW-1:0] addr_o
);
  own_state_e    state_q, state_d;
  logic [DW-1:0] addr_q;

  // external request has priority over a new read
  assign rd_ack_o = (state_q == ST_OWN) && ext_req_ni && rd_req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OWN: begin
        if (!ext_req_ni)   state_d = ST_REL_EXT;
        else if (rd_req_i) state_d = ST_REQ;
      end
      ST_REQ:     if (!rd_rdy_ni) state_d = ST_REL_RD;
      ST_REL_RD:  state_d = ST_SLV_RD;
      ST_REL_EXT: state_d = ST_SLV_EXT;
      ST_SLV_RD:  if (null_i || rd_end_i) state_d = ST_OWN;
      ST_SLV_EXT: if (null_i) state_d = ST_OWN;
      default:    state_d = ST_OWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OWN;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (rd_ack_o) addr_q <= rd_addr_i;
    end
  end

  assign drive_o    = (state_q == ST_OWN) || (state_q == ST_REQ);
  assign req_o      = (state_q == ST_REQ);
  assign rel_o      = (state_q == ST_REL_RD) || (state_q == ST_REL_EXT);
  assign slave_o    = (state_q == ST_SLV_RD) || (state_q == ST_SLV_EXT);
  assign slave_rd_o = (state_q == ST_SLV_RD);
  assign addr_o     = addr_q;
endmodule

// File: rtl/bus_in_decode.sv
module bus_in_decode
  import bus_own_pkg::*;
(
  input  logic             slave_i,
  input  logic             valid_in_ni,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             null_o,
  output logic             wcmd_o,
  output logic             data_o,
  output logic             eod_o
);
  logic strobe;
  logic is_data;

  // valid-in only counts while the agent owns the buses
  assign strobe  = slave_i && !valid_in_ni;
  assign is_data = cmd_i[CMD_DATA_BIT];

  assign data_o = strobe && is_data;
  assign eod_o  = strobe && is_data && cmd_i[CMD_EOD_BIT];
  assign null_o = strobe && !is_data && (cmd_i[2:1] == OP_NULL);
  assign wcmd_o = strobe && !is_data && (cmd_i[2:1] == OP_WRITE);
endmodule

// File: rtl/bus_rsp_capture.sv
module bus_rsp_capture #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slave_rd_i,
  input  logic          null_i,
  input  logic          wcmd_i,
  input  logic          data_i,
  input  logic          eod_i,
  input  logic [DW-1:0] bus_data_i,
  output logic          rd_end_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_data_valid_o,
  output logic          rd_done_o,
  output logic [DW-1:0] wr_reg_o
);
  logic          wr_pend_q;
  logic [DW-1:0] rd_data_q, wr_reg_q;
  logic          rd_vld_q, rd_done_q;
  logic          rd_word;

  assign rd_word  = data_i && !wr_pend_q && slave_rd_i;
  assign rd_end_o = rd_word && eod_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_pend_q <= 1'b0;
      wr_reg_q  <= '0;
      rd_data_q <= '0;
      rd_vld_q  <= 1'b0;
      rd_done_q <= 1'b0;
    end else begin
      rd_vld_q  <= rd_word;
      rd_done_q <= rd_end_o;
      if (rd_word) rd_data_q <= bus_data_i;
      if (wcmd_i) begin
        wr_pend_q <= 1'b1;
      end else if (data_i && wr_pend_q) begin
        wr_reg_q  <= bus_data_i;
        wr_pend_q <= 1'b0;
      end else if (null_i) begin
        wr_pend_q <= 1'b0;
      end
    end
  end

  assign rd_data_o       = rd_data_q;
  assign rd_data_valid_o = rd_vld_q;
  assign rd_done_o       = rd_done_q;
  assign wr_reg_o        = wr_reg_q;
endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
  import bus_own_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_req_i,
  input  logic [DW-1:0]    rd_addr_i,
  output logic             rd_ack_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_data_valid_o,
  output logic             rd_done_o,
  output logic [DW-1:0]    wr_reg_o,
  output logic [DW-1:0]    bus_data_o,
  input  logic [DW-1:0]    bus_data_i,
  output logic [CMD_W-1:0] cmd_o,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             bus_oe_o,
  output logic             valid_out_no,
  input  logic             valid_in_ni,
  input  logic             rd_rdy_ni,
  input  logic             ext_req_ni,
  output logic             release_no
);
  logic          drive, req, rel, slave, slave_rd;
  logic          ev_null, ev_wcmd, ev_data, ev_eod, rd_end;
  logic [DW-1:0] addr;

  bus_own_fsm #(.DW(DW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_req_i   (rd_req_i),
    .rd_addr_i  (rd_addr_i),
    .rd_rdy_ni  (rd_rdy_ni),
    .ext_req_ni (ext_req_ni),
    .null_i     (ev_null),
    .rd_end_i   (rd_end),
    .rd_ack_o   (rd_ack_o),
    .drive_o    (drive),
    .req_o      (req),
    .rel_o      (rel),
    .slave_o    (slave),
    .slave_rd_o (slave_rd),
    .addr_o     (addr)
  );

  bus_in_decode u_dec (
    .slave_i     (slave),
    .valid_in_ni (valid_in_ni),
    .cmd_i       (cmd_i),
    .null_o      (ev_null),
    .wcmd_o      (ev_wcmd),
    .data_o      (ev_data),
    .eod_o       (ev_eod)
  );

  bus_rsp_capture #(.DW(DW)) u_cap (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .slave_rd_i      (slave_rd),
    .null_i          (ev_null),
    .wcmd_i          (ev_wcmd),
    .data_i          (ev_data),
    .eod_i           (ev_eod),
    .bus_data_i      (bus_data_i),
    .rd_end_o        (rd_end),
    .rd_data_o       (rd_data_o),
    .rd_data_valid_o (rd_data_valid_o),
    .rd_done_o       (rd_done_o),
    .wr_reg_o        (wr_reg_o)
  );

  assign bus_oe_o     = drive;
  assign valid_out_no = !req;
  assign release_no   = !rel;
  assign bus_data_o   = req ? addr : '0;
  assign cmd_o        = req ? CMD_READ : CMD_IDLE;
endmodule

// File: rtl/bus_own_ctrl_chk.sv
module bus_own_ctrl_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_oe_o,
  input logic          release_no,
  input logic          valid_out_no,
  input logic          rd_rdy_ni,
  input logic          ext_req_ni,
  input logic          rd_done_o,
  input logic [DW-1:0] bus_data_o
);
  AST_OE_OFF_IN_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !release_no |-> !bus_oe_o); // R11
  AST_OE_WITH_VALID_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_out_no |-> bus_oe_o); // R11
  AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !release_no |=> release_no); // R3
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_out_no && rd_rdy_ni) |=> (!valid_out_no && $stable(bus_data_o))); // R4
  AST_RELEASE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(release_no) |-> ($past(!ext_req_ni) || $past(!rd_rdy_ni))); // R5
  AST_DONE_REOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |-> bus_oe_o); // R7
endmodule

bind bus_own_ctrl bus_own_ctrl_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_oe_o     (bus_oe_o),
  .release_no   (release_no),
  .valid_out_no (valid_out_no),
  .rd_rdy_ni    (rd_rdy_ni),
  .ext_req_ni   (ext_req_ni),
  .rd_done_o    (rd_done_o),
  .bus_data_o   (bus_data_o)
);

// File: tb/tb_bus_own_ctrl.sv
module tb_bus_own_ctrl;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_req = 1'b0;
  logic [DW-1:0] rd_addr = '0;
  logic          rd_ack, rd_vld, rd_done, bus_oe, valid_out_n, release_n;
  logic [DW-1:0] rd_data, wr_reg, bus_out;
  logic [DW-1:0] bus_in = '0;
  logic [3:0]    cmd_out;
  logic [3:0]    cmd_in = 4'b0000;
  logic          valid_in_n = 1'b1;
  logic          rd_rdy_n = 1'b1;
  logic          ext_req_n = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [DW-1:0] exp_q[$];

  always #4 clk = ~clk;

  bus_own_ctrl #(.DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .rd_ack_o(rd_ack), .rd_data_o(rd_data), .rd_data_valid_o(rd_vld),
    .rd_done_o(rd_done), .wr_reg_o(wr_reg), .bus_data_o(bus_out),
    .bus_data_i(bus_in), .cmd_o(cmd_out), .cmd_i(cmd_in), .bus_oe_o(bus_oe),
    .valid_out_no(valid_out_n), .valid_in_ni(valid_in_n), .rd_rdy_ni(rd_rdy_n),
    .ext_req_ni(ext_req_n), .release_no(release_n)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pop expected read words as the design reports them (R6)
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6/R9/R10: actual unexpected word %h expected none", rd_data);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL R6: actual %h expected %h", rd_data, e);
        end
      end
    end
  end

  // drive one agent cycle with valid-in low; expect_rd pushes to scoreboard
  task automatic agent_send(logic [3:0] c, logic [DW-1:0] d, bit expect_rd);
    @(negedge clk);
    valid_in_n = 1'b0; cmd_in = c; bus_in = d;
    if (expect_rd) exp_q.push_back(d);
    @(negedge clk);
    valid_in_n = 1'b1; cmd_in = 4'b0000; bus_in = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(2);
    // R1: reset state
    check("R1 release", {31'b0, release_n}, 1);
    check("R1 valid_out", {31'b0, valid_out_n}, 1);
    check("R1 oe", {31'b0, bus_oe}, 1);
    check("R1 wr_reg", wr_reg, 0);
    check("R1 done", {31'b0, rd_done}, 0);
    rst_n = 1'b1;
    idle(1);

    // R2: read issue, read-ready high
    rd_req = 1'b1; rd_addr = 32'h1000_0040;
    #1 check("R2 ack", {31'b0, rd_ack}, 1);
    @(negedge clk); rd_req = 1'b0; rd_addr = '0;
    check("R2 valid_out", {31'b0, valid_out_n}, 0);
    check("R2 addr", bus_out, 32'h1000_0040);
    check("R2 cmd", {28'b0, cmd_out}, 32'h4);
    check("R2 oe", {31'b0, bus_oe}, 1);
    // R4: hold while not ready
    idle(2);
    check("R4 valid_out held", {31'b0, valid_out_n}, 0);
    check("R4 addr held", bus_out, 32'h1000_0040);
    check("R4 no release", {31'b0, release_n}, 1);
    // R3: ready -> release
    rd_rdy_n = 1'b0;
    @(negedge clk); rd_rdy_n = 1'b1;
    check("R3 release low", {31'b0, release_n}, 0);
    check("R3 valid_out high", {31'b0, valid_out_n}, 1);
    check("R3 oe low", {31'b0, bus_oe}, 0);
    @(negedge clk);
    check("R3 release one cycle", {31'b0, release_n}, 1);
    check("R3 oe stays low", {31'b0, bus_oe}, 0);

    // R6: DDxxDD response, latency gap first
    idle(2);
    agent_send(4'b1000, 32'hA000_0001, 1);
    agent_send(4'b1000, 32'hA000_0002, 1);
    idle(2);
    agent_send(4'b1000, 32'hA000_0003, 1);
    check("R7 not done before last", {31'b0, rd_done}, 0);
    check("R7 oe low before last", {31'b0, bus_oe}, 0);
    agent_send(4'b1001, 32'hA000_0004, 1);
    // agent_send returns one negedge after the edge that took the word
    check("R7 done", {31'b0, rd_done}, 1);
    check("R7 oe back", {31'b0, bus_oe}, 1);
    @(negedge clk);
    check("R7 done pulse", {31'b0, rd_done}, 0);
    check("R6 all words seen", exp_q.size(), 0);

    // R10: valid-in ignored while processor owns the bus
    agent_send(4'b0010, 32'h0, 0);
    agent_send(4'b1001, 32'hDEAD_BEEF, 0);
    agent_send(4'b0000, 32'h0, 0);
    check("R10 wr_reg unchanged", wr_reg, 0);
    check("R10 oe unchanged", {31'b0, bus_oe}, 1);
    check("R10 release unchanged", {31'b0, release_n}, 1);

    // R5: external request wins over read request
    ext_req_n = 1'b0; rd_req = 1'b1; rd_addr = 32'h2222_0000;
    #1 check("R5 read not acked", {31'b0, rd_ack}, 0);
    @(negedge clk); ext_req_n = 1'b1; rd_req = 1'b0;
    check("R5 release low", {31'b0, release_n}, 0);
    check("R5 no valid_out", {31'b0, valid_out_n}, 1);
    check("R5 oe low", {31'b0, bus_oe}, 0);
    @(negedge clk);
    check("R5 release one cycle", {31'b0, release_n}, 1);

    // R9: write command then data word (with EOD flag) updates register
    agent_send(4'b0010, 32'h0, 0);
    agent_send(4'b1001, 32'hCAFE_0001, 0);
    check("R9 wr_reg", wr_reg, 32'hCAFE_0001);
    check("R9 no done", {31'b0, rd_done}, 0);
    check("R9 still slave", {31'b0, bus_oe}, 0);
    // data word without a write command: no register change, no read word
    agent_send(4'b1000, 32'h5555_5555, 0);
    check("R9 wr_reg held", wr_reg, 32'hCAFE_0001);

    // R8: null returns ownership
    agent_send(4'b0000, 32'h0, 0);
    check("R8 oe back", {31'b0, bus_oe}, 1);
    check("R8 no done", {31'b0, rd_done}, 0);

    // second read, ready at once, write interleaved in response
    rd_req = 1'b1; rd_addr = 32'h0000_0FF0; rd_rdy_n = 1'b0;
    @(negedge clk); rd_req = 1'b0;
    check("R2 second addr", bus_out, 32'h0000_0FF0);
    @(negedge clk); rd_rdy_n = 1'b1;
    check("R3 second release", {31'b0, release_n}, 0);
    idle(1);
    agent_send(4'b1000, 32'hB000_0001, 1);
    agent_send(4'b0010, 32'h0, 0);
    agent_send(4'b1001, 32'h0000_7777, 0);
    check("R9 write inside read", wr_reg, 32'h0000_7777);
    check("R9 read not ended", {31'b0, bus_oe}, 0);
    agent_send(4'b1001, 32'hB000_0002, 1);
    check("R7 second done", {31'b0, rd_done}, 1);
    check("R7 second oe", {31'b0, bus_oe}, 1);
    idle(2);
    check("R6 queue empty", exp_q.size(), 0);
    finish_run();
  end
endmodule